// File: doc/BRIEF.md
# Asynchronous Bus Read/Write Master with Acknowledge Handshake

This block is the processor-side end of a system bus whose slaves answer at their own pace. The core hands it a single transfer: an address, a direction and, for writes, a data word. The block places the address on the bus and holds it for a set number of setup cycles. It then raises an address strobe and waits, for as long as needed, for the slave's transfer acknowledge. The acknowledge arrives asynchronously, so it passes through a chain of flip-flops before any logic looks at it.

Once the synchronised acknowledge is seen, the block latches the read bus, drops the strobe and gives the core a one-cycle completion pulse. It then waits for the slave to withdraw its acknowledge before it takes another request. This completes a four-phase handshake. The core sees a stall flag for the whole time the bus is busy. An optional cycle limit ends a strobe that is never answered and reports a bus error with the completion pulse.

Top module: `abus_master`

## Requirements
- R1: While reset is asserted and on the first cycle after it, `strobe`, `stall`, `done`, `bus_err` and `bus_drive` are all low.
- R2: A request is taken only when the block is idle, which is when `stall` is low. A pulse on `req_valid` while `stall` is high starts no transfer. From the cycle after acceptance, `bus_addr` carries the request address. That address is unchanged for `SETUP_CYC` (at least 1) cycles before `strobe` rises and for the whole time `strobe` is high.
- R3: `ack` passes through `SYNC_STAGES` flip-flops. `strobe` stays high for any number of cycles until the synchronised `ack` is seen high.
- R4: On the clock edge where the synchronised `ack` is first seen high during a strobe, `rdata` takes the value of `bus_rdata`, `strobe` falls and `done` rises, all on that same edge.
- R5: A write has `bus_rnw` = 0, `bus_drive` = 1 and `bus_wdata` equal to the request data. A read has `bus_rnw` = 1 and `bus_drive` = 0. These values hold from the setup cycles until the strobe falls.
- R6: `stall` is high from the edge that accepts a request until the transfer is fully released. It stays high after the strobe falls, for as long as the slave keeps `ack` high.
- R7: `strobe` never rises again until `ack` has been seen low through the synchroniser after the previous strobe fell (four-phase handshake).
- R8: With `TIMEOUT` > 0, a strobe that receives no acknowledge for `TIMEOUT` cycles falls after exactly `TIMEOUT` high cycles. `done` then pulses with `bus_err` = 1. `TIMEOUT` = 0 disables the limit.
- R9: `done` is high for exactly one cycle per transfer, and `bus_err` is high only together with `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Core request pulse, taken when idle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW | Transfer address |
| req_wdata | input | DW | Write data |
| stall | output | 1 | Core must wait; bus busy |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | DW | Data captured at acknowledge |
| bus_err | output | 1 | Transfer ended by timeout (with done) |
| bus_addr | output | AW | Address bus |
| bus_wdata | output | DW | Write data bus |
| bus_drive | output | 1 | Master drives the data bus |
| bus_rnw | output | 1 | Direction line, 1 = read |
| strobe | output | 1 | Address-valid strobe |
| ack | input | 1 | Slave transfer acknowledge (asynchronous) |
| bus_rdata | input | DW | Read data bus |

## Verification
The bench builds the block with AW = 8, DW = 16, SETUP_CYC = 1, SYNC_STAGES = 2 and TIMEOUT = 20. With this short limit, an unanswered strobe ends quickly, so the error path and exact strobe length can be checked. Slave latencies of up to ten cycles plus the synchroniser still fit inside the limit. Varied acknowledge hold times after the strobe falls exercise the release wait and the stall it keeps raised.

// File: rtl/abus_pkg.sv
package abus_pkg;
  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_SETUP   = 2'd1,
    ST_STROBE  = 2'd2,
    ST_RELEASE = 2'd3
  } abus_state_e;
endpackage

// File: rtl/abus_sync.sv
module abus_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] ff_q;

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ff_q[0] <= 1'b0;
        else        ff_q[0] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ff_q[i] <= 1'b0;
        else        ff_q[i] <= ff_q[i-1];
      end
    end
  end

  assign q = ff_q[STAGES-1];
endmodule

// File: rtl/abus_wait_timer.sv
module abus_wait_timer #(
  parameter int LIMIT = 20
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic expired
);
  localparam int SPAN = (LIMIT > 1) ? LIMIT : 2;
  localparam int CW   = $clog2(SPAN);
  localparam logic [CW-1:0] LAST = CW'(SPAN - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          at_last;

  assign at_last = (cnt_q == LAST);
  assign expired = (LIMIT != 0) && run &&
                   ((LIMIT == 1) ? 1'b1 : at_last);

  always_comb begin
    cnt_d = cnt_q;
    if (!run)          cnt_d = '0;
    else if (!at_last) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/abus_master.sv
module abus_master
  import abus_pkg::*;
#(
  parameter int AW          = 8,
  parameter int DW          = 16,
  parameter int SETUP_CYC   = 1,
  parameter int SYNC_STAGES = 2,
  parameter int TIMEOUT     = 20
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic          req_write,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  output logic          stall,
  output logic          done,
  output logic [DW-1:0] rdata,
  output logic          bus_err,
  output logic [AW-1:0] bus_addr,
  output logic [DW-1:0] bus_wdata,
  output logic          bus_drive,
  output logic          bus_rnw,
  output logic          strobe,
  input  logic          ack,
  input  logic [DW-1:0] bus_rdata
);
  localparam int SCW = (SETUP_CYC > 1) ? $clog2(SETUP_CYC) : 1;
  localparam logic [SCW-1:0] SETUP_LAST = SCW'(SETUP_CYC - 1);

  abus_state_e   state_q, state_d;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] wdata_q, rdata_q, rdata_d;
  logic          write_q;
  logic [SCW-1:0] setup_q, setup_d;
  logic          strobe_q, strobe_d;
  logic          done_q, done_d;
  logic          err_q, err_d;
  logic          ack_s;
  logic          expired;
  logic          accept;

  abus_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(ack), .q(ack_s)
  );

  abus_wait_timer #(.LIMIT(TIMEOUT)) u_timer (
    .clk(clk), .rst_n(rst_n), .run(state_q == ST_STROBE), .expired(expired)
  );

  assign accept = (state_q == ST_IDLE) && req_valid;

  always_comb begin
    state_d  = state_q;
    setup_d  = setup_q;
    strobe_d = strobe_q;
    rdata_d  = rdata_q;
    done_d   = 1'b0;
    err_d    = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (req_valid) begin
          state_d = ST_SETUP;
          setup_d = '0;
        end
      end
      ST_SETUP: begin
        if (setup_q == SETUP_LAST) begin
          state_d  = ST_STROBE;
          strobe_d = 1'b1;
        end else begin
          setup_d = setup_q + 1'b1;
        end
      end
      ST_STROBE: begin
        if (ack_s) begin
          rdata_d  = bus_rdata;
          done_d   = 1'b1;
          strobe_d = 1'b0;
          state_d  = ST_RELEASE;
        end else if (expired) begin
          done_d   = 1'b1;
          err_d    = 1'b1;
          strobe_d = 1'b0;
          state_d  = ST_RELEASE;
        end
      end
      ST_RELEASE: begin
        if (!ack_s) state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      setup_q  <= '0;
      strobe_q <= 1'b0;
      rdata_q  <= '0;
      done_q   <= 1'b0;
      err_q    <= 1'b0;
    end else begin
      state_q  <= state_d;
      setup_q  <= setup_d;
      strobe_q <= strobe_d;
      rdata_q  <= rdata_d;
      done_q   <= done_d;
      err_q    <= err_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      wdata_q <= '0;
      write_q <= 1'b0;
    end else if (accept) begin
      addr_q  <= req_addr;
      wdata_q <= req_wdata;
      write_q <= req_write;
    end
  end

  assign stall     = (state_q != ST_IDLE);
  assign done      = done_q;
  assign bus_err   = err_q;
  assign rdata     = rdata_q;
  assign strobe    = strobe_q;
  assign bus_addr  = addr_q;
  assign bus_wdata = wdata_q;
  assign bus_rnw   = !write_q;
  assign bus_drive = write_q &&
                     ((state_q == ST_SETUP) || (state_q == ST_STROBE));
endmodule

// File: rtl/abus_master_checks.sv
module abus_master_checks #(
  parameter int AW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          strobe,
  input logic          stall,
  input logic          done,
  input logic          bus_err,
  input logic [AW-1:0] bus_addr,
  input logic          ack_s
);
  p_addr_held_r2: assert property (@(posedge clk) disable iff (!rst_n)
    strobe |-> $stable(bus_addr))
    else $error("address moved under strobe");

  p_fall_with_done_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(strobe) |-> done)
    else $error("strobe fell without done");

  p_stall_in_strobe_r6: assert property (@(posedge clk) disable iff (!rst_n)
    strobe |-> stall)
    else $error("strobe high while not stalled");

  p_four_phase_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(strobe) |-> !ack_s)
    else $error("strobe rose with acknowledge still high");

  p_done_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done)
    else $error("done longer than one cycle");

  p_err_with_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
    bus_err |-> done)
    else $error("bus_err without done");
endmodule

bind abus_master abus_master_checks #(.AW(AW)) u_checks (
  .clk(clk), .rst_n(rst_n), .strobe(strobe), .stall(stall), .done(done),
  .bus_err(bus_err), .bus_addr(bus_addr), .ack_s(ack_s)
);

// File: tb/abus_master_test.sv
module abus_master_test;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 8;
  localparam int DW = 16;
  localparam int TMO = 20;

  logic          clk, rst_n;
  logic          req_valid, req_write;
  logic [AW-1:0] req_addr;
  logic [DW-1:0] req_wdata;
  logic          stall, done, bus_err, bus_drive, bus_rnw, strobe, ack;
  logic [DW-1:0] rdata, bus_wdata, bus_rdata;
  logic [AW-1:0] bus_addr;

  int checks = 0;
  int errors = 0;

  abus_master #(.AW(AW), .DW(DW), .SETUP_CYC(1), .SYNC_STAGES(2),
                .TIMEOUT(TMO)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .stall(stall), .done(done),
    .rdata(rdata), .bus_err(bus_err), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_drive(bus_drive), .bus_rnw(bus_rnw),
    .strobe(strobe), .ack(ack), .bus_rdata(bus_rdata)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [DW-1:0] model(input logic [AW-1:0] a);
    return {a ^ 8'h5A, ~a};
  endfunction

  task automatic check(input bit ok, input string req, input string msg,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, msg, act, exp);
    end
  endtask

  // scoreboard: {err, data}
  logic [DW:0] exp_q[$];

  // slave configuration
  bit            cfg_write, cfg_noresp;
  int            cfg_lat, cfg_hold;
  logic [AW-1:0] cfg_addr;
  logic [DW-1:0] cfg_wdata;

  initial begin
    ack = 1'b0;
    bus_rdata = '0;
    forever begin
      @(negedge clk);
      if (strobe) begin
        if (!cfg_noresp) begin
          repeat (cfg_lat) @(negedge clk);
          bus_rdata = model(bus_addr);
          check(bus_addr == cfg_addr, "R2", "address at ack", 32'(bus_addr), 32'(cfg_addr));
          check(bus_rnw == !cfg_write, "R5", "direction line", 32'(bus_rnw), 32'(!cfg_write));
          check(bus_drive == cfg_write, "R5", "drive enable", 32'(bus_drive), 32'(cfg_write));
          if (cfg_write)
            check(bus_wdata == cfg_wdata, "R5", "write data", 32'(bus_wdata), 32'(cfg_wdata));
          ack = 1'b1;
          while (strobe) @(negedge clk);
          repeat (cfg_hold) begin
            @(negedge clk);
            check(stall, "R6", "stall during ack hold", 32'(stall), 32'd1);
          end
          ack = 1'b0;
        end else begin
          while (strobe) @(negedge clk);
        end
      end
    end
  end

  // monitor
  logic          prev_done, prev_strobe;
  logic [AW-1:0] prev_addr;
  int            ack_low_cnt, hi_cnt, done_cnt;
  initial begin
    prev_done = 0; prev_strobe = 0; prev_addr = '0;
    ack_low_cnt = 0; hi_cnt = 0; done_cnt = 0;
    forever begin
      @(negedge clk);
      if (rst_n) begin
        if (strobe && !prev_strobe) begin
          check(bus_addr == prev_addr, "R2", "address setup before strobe", 32'(bus_addr), 32'(prev_addr));
          check(ack_low_cnt >= 2, "R7", "ack low cycles before new strobe", 32'(ack_low_cnt), 32'd2);
        end
        if (strobe && prev_strobe && bus_addr != prev_addr)
          check(0, "R2", "address changed under strobe", 32'(bus_addr), 32'(prev_addr));
        if (done && prev_done) check(0, "R9", "done wider than one cycle", 32'd2, 32'd1);
        if (bus_err && !done) check(0, "R9", "bus_err without done", 32'd1, 32'd0);
        if (done) begin
          done_cnt++;
          check(!strobe && prev_strobe, "R4", "strobe falls with done", 32'(strobe), 32'd0);
          if (exp_q.size() == 0) begin
            check(0, "R2", "unexpected transfer", 32'd1, 32'd0);
          end else begin
            logic [DW:0] e;
            e = exp_q.pop_front();
            check(bus_err == e[DW], e[DW] ? "R8" : "R9", "error flag", 32'(bus_err), 32'(e[DW]));
            if (e[DW])
              check(hi_cnt == TMO, "R8", "strobe length at timeout", 32'(hi_cnt), 32'(TMO));
            else
              check(rdata == e[DW-1:0], "R4", "captured data", 32'(rdata), 32'(e[DW-1:0]));
          end
        end
        hi_cnt      = strobe ? hi_cnt + 1 : 0;
        ack_low_cnt = ack ? 0 : ack_low_cnt + 1;
        prev_done   = done;
        prev_strobe = strobe;
        prev_addr   = bus_addr;
      end
    end
  end

  task automatic xfer(input bit wr, input logic [AW-1:0] a, input logic [DW-1:0] wd,
                      input int lat, input int hold, input bit nr, input bit poke);
    while (stall) @(negedge clk);
    cfg_write = wr; cfg_addr = a; cfg_wdata = wd;
    cfg_lat = lat; cfg_hold = hold; cfg_noresp = nr;
    exp_q.push_back({nr, model(a)});
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = wd;
    @(negedge clk);
    req_valid = 1'b0;
    check(stall, "R6", "stall after accept", 32'(stall), 32'd1);
    if (poke) begin
      @(negedge clk);
      req_valid = 1'b1; req_write = 1'b0; req_addr = ~a;
      @(negedge clk);
      req_valid = 1'b0;
    end
    while (!done) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0;
    req_addr = '0; req_wdata = '0;
    cfg_noresp = 0; cfg_lat = 0; cfg_hold = 0; cfg_write = 0;
    cfg_addr = '0; cfg_wdata = '0;
    repeat (3) @(negedge clk);
    check(!strobe && !stall && !done && !bus_err && !bus_drive, "R1", "reset outputs",
          {27'd0, strobe, stall, done, bus_err, bus_drive}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!strobe && !stall && !done && !bus_err && !bus_drive, "R1", "after reset",
          {27'd0, strobe, stall, done, bus_err, bus_drive}, 32'd0);

    xfer(0, 8'h12, '0, 0, 0, 0, 0);        // R4 fastest read
    xfer(0, 8'hA7, '0, 5, 3, 0, 1);        // R3 slow read, R2 poke ignored
    xfer(1, 8'h3C, 16'hBEEF, 2, 1, 0, 0);  // R5 write
    xfer(0, 8'hFF, '0, 10, 6, 0, 0);       // R3/R7 long latency, long hold
    xfer(0, 8'h00, '0, 0, 0, 1, 0);        // R8 timeout
    xfer(1, 8'h81, 16'h1234, 1, 4, 0, 1);  // R5/R6 write after error
    xfer(0, 8'h55, '0, 3, 2, 0, 0);        // R4 read

    repeat (10) @(negedge clk);
    check(done_cnt == 7, "R9", "done pulses per transfer", 32'(done_cnt), 32'd7);
    check(exp_q.size() == 0, "R2", "scoreboard drained", 32'(exp_q.size()), 32'd0);
    check(!stall && !strobe, "R6", "idle at end", {30'd0, stall, strobe}, 32'd0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule